// File: doc/BRIEF.md
# Bit Rotate, Shift and Test Unit

A purely combinational datapath slice for an 8-bit processor core. It takes one operand byte, the current carry flag, a bit index and an operation select. It returns the transformed byte, a new four-bit flag value, and two write enables. One enable is for the result and one is for the flags.

It serves two groups of instructions. The first group is the two-byte bit-manipulation set: eight rotate, shift and swap variants, plus test, clear and set of a single bit. The second group is the four one-byte accumulator rotates. These share the rotate datapath but treat the zero flag differently.

Fetching the operand and writing the result back are done by the surrounding core, which is guided by the two enables. The operand width is a parameter with a default of 8.

Top module: `bitrot_unit`

## Requirements
- R1: Select 0 rotates left with bit 7 copied into both bit 0 and carry. Select 1 rotates right with bit 0 copied into both bit 7 and carry.
- R2: Select 2 rotates left through carry: bit 7 goes to carry and the incoming carry goes to bit 0. Select 3 rotates right through carry: bit 0 goes to carry and the incoming carry goes to bit 7.
- R3: Select 4 shifts left, filling bit 0 with zero, with bit 7 going to carry. Select 5 shifts right, keeping bit 7, with bit 0 going to carry. Select 7 shifts right, filling bit 7 with zero, with bit 0 going to carry.
- R4: Select 6 exchanges the upper and lower nibbles and clears carry.
- R5: For selects 0 to 7, the flag nibble (bit 3 zero, bit 2 subtract, bit 1 half-carry, bit 0 carry) has zero set exactly when the result is 0, and subtract and half-carry cleared. Both enables are high.
- R6: Selects 12, 13, 14 and 15 give the same result and carry as selects 0, 1, 2 and 3, but the zero flag is always 0. Subtract and half-carry are 0 and both enables are high.
- R7: Select 8 tests operand bit `bit_idx`, where index 0 is the LSB. Zero is set when that bit is 0, subtract is 0, half-carry is 1, and carry equals `carry_in`. The flag enable is high and the result enable is low.
- R8: Select 9 clears and select 10 sets operand bit `bit_idx` and changes no other bit. The flag enable is low and the result enable is high.
- R9: When the flag enable is low, `flags_out` is 0. Select 11 raises neither enable.
- R10: Whenever the result enable is low, `result` equals `operand`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel | input | 4 | Operation select (encoding in R1 to R9) |
| operand | input | DATA_W | Operand byte |
| carry_in | input | 1 | Current carry flag |
| bit_idx | input | log2(DATA_W) | Bit index for test, clear and set |
| result | output | DATA_W | Transformed operand |
| flags_out | output | 4 | New flags {zero, subtract, half-carry, carry} |
| flag_we | output | 1 | Flags should be written |
| result_we | output | 1 | Result should be written back |

## Verification
The unit holds no state, so any internal fault shows at the ports in the same cycle the select and operand are applied. A fault in the shift select decode mixes up where the edge bits and carry go. A wrong one-hot mask in the bit path touches a neighbouring bit or reads the wrong bit. Both appear at once in `result` or in the zero flag. The bench walks every select against edge-heavy operands, both carry values and every index, so each such fault is exposed on the first affected combination.

// File: rtl/bitrot_pkg.sv
// Shared encodings for the bit rotate, shift and test unit.
// Assumes a 4-bit select; the numeric values are part of the block's contract.
package bitrot_pkg;
    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        OP_ROL  = 4'd0,
        OP_ROR  = 4'd1,
        OP_RCL  = 4'd2,
        OP_RCR  = 4'd3,
        OP_SHL  = 4'd4,
        OP_SAR  = 4'd5,
        OP_SWP  = 4'd6,
        OP_SHR  = 4'd7,
        OP_TST  = 4'd8,
        OP_CLR  = 4'd9,
        OP_SET  = 4'd10,
        OP_NOP  = 4'd11,
        OP_AROL = 4'd12,
        OP_AROR = 4'd13,
        OP_ARCL = 4'd14,
        OP_ARCR = 4'd15
    } op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;
endpackage

// File: rtl/bitrot_shifter.sv
// Rotate / shift / swap datapath.
// Assumes W is even (swap splits it into two halves) and W >= 2.
// kind: 0 rol, 1 ror, 2 rol via carry, 3 ror via carry, 4 shl, 5 sar, 6 swap, 7 shr.
module bitrot_shifter #(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd,
    input  logic         cin,
    input  logic [2:0]   kind,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int HALF = W / 2;

    // Pick the shifted value and the bit that leaves the operand.
    always_comb begin
        res  = opnd;
        cout = 1'b0;
        case (kind)
            3'd0: begin res = {opnd[W-2:0], opnd[W-1]}; cout = opnd[W-1]; end
            3'd1: begin res = {opnd[0], opnd[W-1:1]};   cout = opnd[0];   end
            3'd2: begin res = {opnd[W-2:0], cin};       cout = opnd[W-1]; end
            3'd3: begin res = {cin, opnd[W-1:1]};       cout = opnd[0];   end
            3'd4: begin res = {opnd[W-2:0], 1'b0};      cout = opnd[W-1]; end
            3'd5: begin res = {opnd[W-1], opnd[W-1:1]}; cout = opnd[0];   end
            3'd6: begin res = {opnd[HALF-1:0], opnd[W-1:HALF]}; cout = 1'b0; end
            default: begin res = {1'b0, opnd[W-1:1]};   cout = opnd[0];   end
        endcase
    end
endmodule

// File: rtl/bitrot_bitop.sv
// Single-bit test, clear and set datapath.
// Assumes idx is always below W (W a power of two makes this automatic).
module bitrot_bitop #(
    parameter int W  = 8,
    parameter int IX = $clog2(W)
) (
    input  logic [W-1:0]  opnd,
    input  logic [IX-1:0] idx,
    input  logic          do_set,
    output logic [W-1:0]  upd,
    output logic          bit_val
);
    logic [W-1:0] mask;

    // One-hot mask of the addressed bit.
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign mask[i] = (idx == IX'(i));
    end

    // Apply the mask for set or clear, and read the addressed bit.
    always_comb begin
        upd     = do_set ? (opnd | mask) : (opnd & ~mask);
        bit_val = |(opnd & mask);
    end
endmodule

// File: rtl/bitrot_flags.sv
// Flag nibble and write-enable generation for every select.
// Assumes the select encoding of bitrot_pkg.
module bitrot_flags
    import bitrot_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             sh_zero,
    input  logic             sh_cout,
    input  logic             bit_val,
    input  logic             cin,
    output flags_t           flg,
    output logic             flag_we,
    output logic             res_we
);
    // Decode the select into flag values and write enables.
    always_comb begin
        flg     = '0;
        flag_we = 1'b0;
        res_we  = 1'b0;
        case (op_e'(sel))
            OP_ROL, OP_ROR, OP_RCL, OP_RCR,
            OP_SHL, OP_SAR, OP_SWP, OP_SHR: begin
                flg.z   = sh_zero;
                flg.c   = sh_cout;
                flag_we = 1'b1;
                res_we  = 1'b1;
            end
            OP_AROL, OP_AROR, OP_ARCL, OP_ARCR: begin
                flg.c   = sh_cout;
                flag_we = 1'b1;
                res_we  = 1'b1;
            end
            OP_TST: begin
                flg.z   = ~bit_val;
                flg.h   = 1'b1;
                flg.c   = cin;
                flag_we = 1'b1;
            end
            OP_CLR, OP_SET: res_we = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/bitrot_unit.sv
// Top of the bit rotate, shift and test unit. Purely combinational.
// Assumes DATA_W is even and a power of two; the caller performs operand
// fetch and write-back using result_we and flag_we.
module bitrot_unit
    import bitrot_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] operand,
    input  logic              carry_in,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        flags_out,
    output logic              flag_we,
    output logic              result_we
);
    logic [2:0]        sh_kind;
    logic [DATA_W-1:0] sh_res;
    logic              sh_cout;
    logic [DATA_W-1:0] bit_res;
    logic              bit_val;
    flags_t            flg;
    logic              is_shift;
    logic              is_bitwr;

    // Map accumulator rotate selects onto the matching rotate kinds.
    always_comb begin
        sh_kind  = sel[3] ? {1'b0, sel[1:0]} : sel[2:0];
        is_shift = !sel[3] || (sel[3:2] == 2'b11);
        is_bitwr = (op_e'(sel) == OP_CLR) || (op_e'(sel) == OP_SET);
    end

    bitrot_shifter #(.W(DATA_W)) u_shift (
        .opnd (operand),
        .cin  (carry_in),
        .kind (sh_kind),
        .res  (sh_res),
        .cout (sh_cout)
    );

    bitrot_bitop #(.W(DATA_W), .IX(IDX_W)) u_bit (
        .opnd    (operand),
        .idx     (bit_idx),
        .do_set  (sel[1]),
        .upd     (bit_res),
        .bit_val (bit_val)
    );

    bitrot_flags u_flags (
        .sel     (sel),
        .sh_zero (sh_res == '0),
        .sh_cout (sh_cout),
        .bit_val (bit_val),
        .cin     (carry_in),
        .flg     (flg),
        .flag_we (flag_we),
        .res_we  (result_we)
    );

    // Choose the output byte by datapath.
    always_comb begin
        if (is_bitwr)      result = bit_res;
        else if (is_shift) result = sh_res;
        else               result = operand;
        flags_out = flg;
    end
endmodule

// File: rtl/bitrot_unit_chk.sv
// Assertion checker for bitrot_unit. Immediate checks, because the unit has no clock.
module bitrot_unit_chk
    import bitrot_pkg::*;
#(
    parameter int W  = 8,
    parameter int IX = $clog2(W)
) (
    input logic [SEL_W-1:0] sel,
    input logic [W-1:0]     operand,
    input logic             carry_in,
    input logic [IX-1:0]    bit_idx,
    input logic [W-1:0]     result,
    input logic [3:0]       flags_out,
    input logic             flag_we,
    input logic             result_we
);
    // Relate outputs to the select and operand.
    always_comb begin
        if (op_e'(sel) == OP_CLR || op_e'(sel) == OP_SET) begin
            a_r8_no_flag_write: assert (!flag_we);
            a_r8_single_bit: assert ($countones(result ^ operand) <= 1);
        end
        if (op_e'(sel) == OP_SET)
            a_r8_target_set: assert (result[bit_idx]);
        if (op_e'(sel) == OP_TST) begin
            a_r7_no_result_write: assert (!result_we);
            a_r7_carry_kept: assert (flags_out[0] == carry_in);
        end
        if (sel[3:2] == 2'b11)
            a_r6_acc_zero_clear: assert (!flags_out[3]);
        if (op_e'(sel) == OP_SWP)
            a_r4_swap_carry: assert (!flags_out[0]);
        if (!sel[3])
            a_r5_zero_flag: assert (flags_out[3] == (result == '0));
        if (!flag_we)
            a_r9_quiet_flags: assert (flags_out == 4'h0);
        if (!result_we)
            a_r10_passthrough: assert (result == operand);
    end
endmodule

bind bitrot_unit bitrot_unit_chk #(.W(DATA_W)) u_chk (
    .sel       (sel),
    .operand   (operand),
    .carry_in  (carry_in),
    .bit_idx   (bit_idx),
    .result    (result),
    .flags_out (flags_out),
    .flag_we   (flag_we),
    .result_we (result_we)
);

// File: tb/tb_bitrot_unit.sv
module tb_bitrot_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic [3:0] sel = 4'd11;
    logic [7:0] operand = 8'h00;
    logic       carry_in = 1'b0;
    logic [2:0] bit_idx = 3'd0;
    logic [7:0] result;
    logic [3:0] flags_out;
    logic       flag_we;
    logic       result_we;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitrot_unit dut (
        .sel(sel), .operand(operand), .carry_in(carry_in), .bit_idx(bit_idx),
        .result(result), .flags_out(flags_out), .flag_we(flag_we), .result_we(result_we)
    );

    function automatic string tag_of(input int s);
        case (s)
            0, 1:          return "R1";
            2, 3:          return "R2";
            4, 5, 7:       return "R3";
            6:             return "R4";
            8:             return "R7";
            9, 10:         return "R8";
            11:            return "R9";
            default:       return "R6";
        endcase
    endfunction

    // Behavioural reference built from the requirements with integer arithmetic.
    task automatic model(input int s, input int a, input int c, input int ix,
                         output int r, output int f, output int fwe, output int rwe);
        int b7, b0, z, h, cy, bit_sel;
        b7 = (a / 128) % 2;
        b0 = a % 2;
        bit_sel = (a >> ix) % 2;
        z = 0; h = 0; cy = 0; fwe = 1; rwe = 1; r = a;
        case (s)
            0, 12: begin r = (a * 2) % 256 + b7; cy = b7; end
            1, 13: begin r = a / 2 + b0 * 128;   cy = b0; end
            2, 14: begin r = (a * 2) % 256 + c;  cy = b7; end
            3, 15: begin r = a / 2 + c * 128;    cy = b0; end
            4:     begin r = (a * 2) % 256;      cy = b7; end
            5:     begin r = a / 2 + b7 * 128;   cy = b0; end
            6:     begin r = (a % 16) * 16 + a / 16; cy = 0; end
            7:     begin r = a / 2;              cy = b0; end
            8:     begin z = (bit_sel == 0) ? 1 : 0; h = 1; cy = c; rwe = 0; end
            9:     begin r = a - bit_sel * (1 << ix); fwe = 0; end
            10:    begin r = a + (1 - bit_sel) * (1 << ix); fwe = 0; end
            default: begin fwe = 0; rwe = 0; end
        endcase
        if (s < 8) z = (r == 0) ? 1 : 0;
        f = fwe ? (z * 8 + h * 2 + cy) : 0;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: sel=%0d op=%02h c=%0d idx=%0d actual=%0h expected=%0h",
                     req, what, sel, operand, carry_in, bit_idx, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        int ops [9] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'hA5, 8'h5A, 8'h3C, 8'h81, 8'h7E};
        int er, ef, efwe, erwe;
        // Idle state: select 11 passes operand and writes nothing (R9, R10).
        @(negedge clk);
        check("R9", "idle enables", {flag_we, result_we}, 0);
        check("R10", "idle result", result, 0);
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 9; k++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int ix = 0; ix < 8; ix++) begin
                        @(posedge clk);
                        sel = 4'(s); operand = 8'(ops[k]); carry_in = c[0]; bit_idx = 3'(ix);
                        @(negedge clk);
                        model(s, ops[k], c, ix, er, ef, efwe, erwe);
                        check(tag_of(s), "result", result, er);
                        check((s < 8) ? "R5" : tag_of(s), "flags", flags_out, ef);
                        check((s < 8) ? "R5" : tag_of(s), "enables", {flag_we, result_we}, efwe * 2 + erwe);
                        if (erwe == 0) check("R10", "passthrough", result, ops[k]);
                    end
                end
            end
        end
        finish_run();
    end
endmodule